// File: doc/BRIEF.md
# Dual-Mode Host Register Port

This block holds a bank of eight byte-wide registers that set the behaviour of a modem datapath, and gives a host two ways to reach them. In parallel mode the host drives a multiplexed address/data bus: it puts the register address on the low bus bits while the address-latch strobe is high, then reads or writes data on the same bus under active-low read and write strobes. In serial mode the host selects the register on three dedicated address lines and moves data one bit at a time on a single data line. A separate shift clock marks each bit, and the same read and write strobes frame each transfer.

Two of the eight locations are read-only status slots. The detect slot (address 1) and the identity slot (address 6) follow the status inputs from the surrounding logic, and host writes to them have no effect. The six other registers reset to zero. The whole bank is presented on one flat output bus for the datapath. All strobes and the shift clock are sampled on the system clock, so every action takes place on a detected edge.

Top module: `dual_mode_regport`

## Requirements
- R1: After synchronous reset, all six read/write registers are 0x00 on `regs_o`, and both `bus_oe` and `sdata_oe` are low.
- R2: In parallel mode, the address is taken from `bus_i[2:0]` on every clock while `ale` is high, and it is held after `ale` falls, even when the bus then carries data.
- R3: In parallel mode, the byte on `bus_i` in the last cycle that `wr_n` is low is written to the latched address on the clock that sees `wr_n` back high. The new value shows on `regs_o` from that edge on.
- R4: In parallel mode, one clock after `rd_n` is seen low, `bus_oe` is high and `bus_o` holds the selected register. One clock after `rd_n` is seen high, `bus_oe` is low.
- R5: In serial mode, the clock that first sees `rd_n` low loads the register selected by `addr_i`, and bit 0 appears on `sdata_o` after that edge. Each later rising edge of `exclk` while `rd_n` stays low moves to the next bit, LSB first. `sdata_oe` is high one clock after `rd_n` is seen low.
- R6: In serial mode, with `rd_n` and `wr_n` both high, each rising edge of `exclk` shifts `sdata_i` in LSB first, and the last eight bits are kept. The register at `addr_i` takes that byte on the clock that sees `wr_n` rise.
- R7: A serial write commits nothing unless at least eight bits were shifted in since the last read strobe or write commit. A partial transfer is dropped and its count is cleared.
- R8: Slot 1 (detect) shows `det_i` and slot 6 (identity) shows `id_i`, each delayed by one clock. Reads in either mode return those values.
- R9: Host writes to address 1 or address 6 leave those slots unchanged in both modes.
- R10: `bus_oe` is never high in serial mode, `sdata_oe` is never high in parallel mode, and the two are never high together.
- R11: Register n sits at bits [8n+7:8n] of `regs_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | Host access mode: 0 parallel, 1 serial |
| ale | input | 1 | Address latch strobe for parallel mode |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| bus_i | input | 8 | Multiplexed address/data bus, inbound |
| bus_o | output | 8 | Parallel read data |
| bus_oe | output | 1 | Drive enable for the parallel bus |
| addr_i | input | 3 | Register select for serial mode |
| exclk | input | 1 | Serial bit clock, sampled |
| sdata_i | input | 1 | Serial write data |
| sdata_o | output | 1 | Serial read data |
| sdata_oe | output | 1 | Drive enable for the serial data line |
| det_i | input | 8 | Detect status from internal logic |
| id_i | input | 8 | Identity value from internal logic |
| regs_o | output | 64 | All eight registers, register n at bits [8n+7:8n] |

## Verification
A register write shows on `regs_o` on the same clock edge that sees the write strobe rise, because the commit is registered at that edge. Parallel read data and both output enables follow the read strobe by one edge. A serial read gives bit 0 after the edge that sees the read strobe fall, and each sampled rising edge of `exclk` moves to the next bit. The bench drives every input one nanosecond after a rising edge and samples the outputs one nanosecond after the edge that should produce the result. This means each check lands in the exact cycle the requirement names and not a cycle later.

// File: rtl/regport_pkg.sv
package regport_pkg;
  typedef enum logic {
    HOST_PAR = 1'b0,
    HOST_SER = 1'b1
  } host_mode_e;
endpackage

// File: rtl/rp_edge_det.sv
module rp_edge_det #(
  parameter logic RST_VAL = 1'b0,
  parameter bit   RISE    = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic sig,
  output logic edge_o
);
  logic q;

  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else     q <= sig;
  end

  generate
    if (RISE) begin : g_rise
      assign edge_o = sig & ~q;
    end else begin : g_fall
      assign edge_o = ~sig & q;
    end
  endgenerate
endmodule

// File: rtl/rp_serial_shift.sv
module rp_serial_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              ex_rise,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              rd_start,
  input  logic              wr_done,
  input  logic              sdi,
  input  logic [DATA_W-1:0] load_val,
  output logic              sdo,
  output logic [DATA_W-1:0] in_word,
  output logic              in_full
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

  logic [DATA_W-1:0] sr_in, sr_out;
  logic [CNT_W-1:0]  in_cnt, out_cnt;

  // outbound: load on read start, advance per sampled shift clock
  always_ff @(posedge clk) begin
    if (rst) begin
      sr_out  <= '0;
      out_cnt <= '0;
    end else if (rd_start) begin
      sr_out  <= load_val;
      out_cnt <= '0;
    end else if (rd_n && wr_n) begin
      out_cnt <= '0;
    end else if (en && !rd_n && ex_rise && out_cnt < FULL) begin
      sr_out  <= sr_out >> 1;
      out_cnt <= out_cnt + 1'b1;
    end
  end

  // inbound: shift while idle, count saturates at a full byte
  always_ff @(posedge clk) begin
    if (rst) begin
      sr_in  <= '0;
      in_cnt <= '0;
    end else if (!rd_n || wr_done) begin
      in_cnt <= '0;
    end else if (en && wr_n && ex_rise) begin
      sr_in <= {sdi, sr_in[DATA_W-1:1]};
      if (in_cnt < FULL) in_cnt <= in_cnt + 1'b1;
    end
  end

  assign sdo     = sr_out[0];
  assign in_word = sr_in;
  assign in_full = (in_cnt == FULL);
endmodule

// File: rtl/rp_reg_bank.sv
module rp_reg_bank #(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 3,
  parameter int DET_ADDR = 1,
  parameter int ID_ADDR  = 6
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            we,
  input  logic [ADDR_W-1:0]               waddr,
  input  logic [DATA_W-1:0]               wdata,
  input  logic [ADDR_W-1:0]               raddr,
  input  logic [DATA_W-1:0]               det_i,
  input  logic [DATA_W-1:0]               id_i,
  output logic [DATA_W-1:0]               rdata,
  output logic [(1<<ADDR_W)*DATA_W-1:0]   all_o
);
  localparam int NREG = 1 << ADDR_W;

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_slot
      logic [DATA_W-1:0] q;
      if (i == DET_ADDR) begin : g_det
        always_ff @(posedge clk) begin
          if (rst) q <= '0;
          else     q <= det_i;
        end
      end else if (i == ID_ADDR) begin : g_id
        always_ff @(posedge clk) begin
          if (rst) q <= '0;
          else     q <= id_i;
        end
      end else begin : g_rw
        always_ff @(posedge clk) begin
          if (rst)                                    q <= '0;
          else if (we && waddr == ADDR_W'(i))         q <= wdata;
        end
      end
      assign all_o[i*DATA_W +: DATA_W] = q;
    end
  endgenerate

  assign rdata = all_o[raddr*DATA_W +: DATA_W];
endmodule

// File: rtl/dual_mode_regport.sv
module dual_mode_regport
  import regport_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 3,
  parameter int DET_ADDR = 1,
  parameter int ID_ADDR  = 6
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          mode_sel,
  input  logic                          ale,
  input  logic                          rd_n,
  input  logic                          wr_n,
  input  logic [DATA_W-1:0]             bus_i,
  output logic [DATA_W-1:0]             bus_o,
  output logic                          bus_oe,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic                          exclk,
  input  logic                          sdata_i,
  output logic                          sdata_o,
  output logic                          sdata_oe,
  input  logic [DATA_W-1:0]             det_i,
  input  logic [DATA_W-1:0]             id_i,
  output logic [(1<<ADDR_W)*DATA_W-1:0] regs_o
);
  logic              serial;
  logic              ex_rise, wr_rise, rd_fall;
  logic [ADDR_W-1:0] par_addr, cur_addr;
  logic [DATA_W-1:0] par_wdata, wdata, rdata, in_word;
  logic              in_full, we;

  assign serial = (host_mode_e'(mode_sel) == HOST_SER);

  rp_edge_det #(.RST_VAL(1'b0), .RISE(1'b1)) u_ex_edge (
    .clk(clk), .rst(rst), .sig(exclk), .edge_o(ex_rise));
  rp_edge_det #(.RST_VAL(1'b1), .RISE(1'b1)) u_wr_edge (
    .clk(clk), .rst(rst), .sig(wr_n), .edge_o(wr_rise));
  rp_edge_det #(.RST_VAL(1'b1), .RISE(1'b0)) u_rd_edge (
    .clk(clk), .rst(rst), .sig(rd_n), .edge_o(rd_fall));

  // parallel side: address latch and write-data capture
  always_ff @(posedge clk) begin
    if (rst) begin
      par_addr  <= '0;
      par_wdata <= '0;
    end else begin
      if (!serial && ale) par_addr  <= bus_i[ADDR_W-1:0];
      if (!wr_n)          par_wdata <= bus_i;
    end
  end

  assign cur_addr = serial ? addr_i  : par_addr;
  assign wdata    = serial ? in_word : par_wdata;
  assign we       = wr_rise && (serial ? in_full : 1'b1);

  rp_serial_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .en(serial), .ex_rise(ex_rise),
    .rd_n(rd_n), .wr_n(wr_n), .rd_start(rd_fall && serial),
    .wr_done(wr_rise), .sdi(sdata_i), .load_val(rdata),
    .sdo(sdata_o), .in_word(in_word), .in_full(in_full));

  rp_reg_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W),
                .DET_ADDR(DET_ADDR), .ID_ADDR(ID_ADDR)) u_bank (
    .clk(clk), .rst(rst), .we(we), .waddr(cur_addr), .wdata(wdata),
    .raddr(cur_addr), .det_i(det_i), .id_i(id_i),
    .rdata(rdata), .all_o(regs_o));

  // registered read path and drive enables
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_o    <= '0;
      bus_oe   <= 1'b0;
      sdata_oe <= 1'b0;
    end else begin
      bus_o    <= rdata;
      bus_oe   <= !serial && !rd_n;
      sdata_oe <= serial && !rd_n;
    end
  end
endmodule

// File: rtl/regport_checker.sv
module regport_checker #(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 3,
  parameter int DET_ADDR = 1,
  parameter int ID_ADDR  = 6
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          mode_sel,
  input logic                          rd_n,
  input logic                          wr_n,
  input logic                          bus_oe,
  input logic                          sdata_oe,
  input logic [DATA_W-1:0]             det_i,
  input logic [(1<<ADDR_W)*DATA_W-1:0] regs_o
);
  localparam int NREG = 1 << ADDR_W;

  logic [1:0] age;
  logic [NREG*DATA_W-1:0] rw_view;

  always_ff @(posedge clk) begin
    if (rst)             age <= '0;
    else if (age != 2'd2) age <= age + 1'b1;
  end

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_view
      if (i == DET_ADDR || i == ID_ADDR) begin : g_ro
        assign rw_view[i*DATA_W +: DATA_W] = '0;
      end else begin : g_rw
        assign rw_view[i*DATA_W +: DATA_W] = regs_o[i*DATA_W +: DATA_W];
      end
    end
  endgenerate

  // R3 R6 R9: writable slots move only on a write-strobe rising edge
  p_rw_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2 && !($past(wr_n) && !$past(wr_n, 2))) |-> $stable(rw_view));

  p_det_track_r8: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0) |-> regs_o[DET_ADDR*DATA_W +: DATA_W] == $past(det_i));

  p_bus_oe_r4: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0) |-> bus_oe == $past(!rd_n && !mode_sel));

  p_ser_oe_r5: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0) |-> sdata_oe == $past(!rd_n && mode_sel));

  p_oe_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(bus_oe && sdata_oe));
endmodule

bind dual_mode_regport regport_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DET_ADDR(DET_ADDR), .ID_ADDR(ID_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .mode_sel(mode_sel), .rd_n(rd_n), .wr_n(wr_n),
  .bus_oe(bus_oe), .sdata_oe(sdata_oe), .det_i(det_i), .regs_o(regs_o));

// File: tb/dual_mode_regport_bench.sv
module dual_mode_regport_bench;
  localparam logic [7:0] DET_V = 8'h3C;
  localparam logic [7:0] ID_V  = 8'h5A;

  logic clk = 1'b0, rst = 1'b1;
  logic mode_sel = 1'b0, ale = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] bus_i = '0, det_i = DET_V, id_i = ID_V;
  logic [2:0] addr_i = '0;
  logic exclk = 1'b0, sdata_i = 1'b0;
  logic [7:0] bus_o;
  logic bus_oe, sdata_o, sdata_oe;
  logic [63:0] regs_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_mode_regport u_dual_mode_regport (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .ale(ale), .rd_n(rd_n),
    .wr_n(wr_n), .bus_i(bus_i), .bus_o(bus_o), .bus_oe(bus_oe),
    .addr_i(addr_i), .exclk(exclk), .sdata_i(sdata_i), .sdata_o(sdata_o),
    .sdata_oe(sdata_oe), .det_i(det_i), .id_i(id_i), .regs_o(regs_o));

  // {addr, write data, expected read value}
  localparam logic [18:0] VEC [8] = '{
    {3'd0, 8'hA5, 8'hA5}, {3'd1, 8'hFF, DET_V}, {3'd2, 8'h01, 8'h01},
    {3'd3, 8'h80, 8'h80}, {3'd4, 8'h7E, 8'h7E}, {3'd5, 8'hC3, 8'hC3},
    {3'd6, 8'h00, ID_V},  {3'd7, 8'h19, 8'h19}};

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input logic [63:0] act, input logic [63:0] exp,
                       input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] slot(input int n);
    return regs_o[n*8 +: 8];
  endfunction

  task automatic par_write(input logic [2:0] a, input logic [7:0] d);
    ale = 1'b1; bus_i = {5'b10101, a}; tick();
    ale = 1'b0; bus_i = d; wr_n = 1'b0; tick();
    wr_n = 1'b1; bus_i = 8'hEE; tick();
  endtask

  task automatic par_read(input logic [2:0] a, input logic [7:0] exp,
                          input string tag);
    ale = 1'b1; bus_i = {5'b01010, a}; tick();
    ale = 1'b0; bus_i = 8'h00; rd_n = 1'b0; tick();
    check(bus_oe, 1, {tag, " R4 oe"});
    check(bus_o, exp, {tag, " R2 data"});
    rd_n = 1'b1; tick();
    check(bus_oe, 0, {tag, " R4 oe off"});
  endtask

  task automatic ser_shift(input logic [15:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      sdata_i = bits[i]; exclk = 1'b1; tick();
      exclk = 1'b0; tick();
    end
  endtask

  task automatic ser_commit();
    wr_n = 1'b0; tick();
    wr_n = 1'b1; tick();
  endtask

  task automatic ser_read(input logic [2:0] a, input logic [7:0] exp,
                          input string tag);
    logic [7:0] got;
    addr_i = a; rd_n = 1'b0; tick();
    check(sdata_oe, 1, {tag, " R5 oe"});
    for (int k = 0; k < 8; k++) begin
      got[k] = sdata_o;
      check(bus_oe, 0, {tag, " R10 no bus drive"});
      if (k < 7) begin
        exclk = 1'b1; tick(); exclk = 1'b0; tick();
      end
    end
    check(got, exp, {tag, " R5 bits"});
    rd_n = 1'b1; tick();
    check(sdata_oe, 0, {tag, " R5 oe off"});
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst = 1'b0;
    check(bus_oe, 0, "R1 bus_oe");
    check(sdata_oe, 0, "R1 sdata_oe");
    for (int n = 0; n < 8; n++)
      if (n != 1 && n != 6) check(slot(n), 0, "R1 reset value");
    tick();
    check(slot(1), DET_V, "R8 detect slot");
    check(slot(6), ID_V, "R8 id slot");

    // table: parallel write then read back
    for (int v = 0; v < 8; v++) begin
      par_write(VEC[v][18:16], VEC[v][15:8]);
      check(slot(int'(VEC[v][18:16])), VEC[v][7:0], "R3 R9 R11 slot");
      par_read(VEC[v][18:16], VEC[v][7:0], "R3 table");
    end

    // R2: address held while bus carries other data
    ale = 1'b1; bus_i = 8'h04; tick();
    ale = 1'b0; bus_i = 8'h07; tick(); tick();
    rd_n = 1'b0; tick();
    check(bus_o, 8'h7E, "R2 addr hold");
    rd_n = 1'b1; tick();

    // serial mode
    mode_sel = 1'b1; tick();
    addr_i = 3'd2; ser_shift(16'h0096, 8); ser_commit();
    check(slot(2), 8'h96, "R6 serial write");
    ser_read(3'd2, 8'h96, "R6 readback");
    ser_read(3'd5, 8'hC3, "R5 serial read");

    addr_i = 3'd2; ser_shift(16'h001F, 5); ser_commit();
    check(slot(2), 8'h96, "R7 partial write dropped");
    ser_shift(16'h0011, 3); ser_commit();
    check(slot(2), 8'h96, "R7 count cleared");

    addr_i = 3'd3; ser_shift(16'h007D, 9); ser_commit();
    check(slot(3), 8'h3E, "R6 last eight kept");

    addr_i = 3'd1; ser_shift(16'h00AA, 8); ser_commit();
    check(slot(1), DET_V, "R9 serial detect write");
    addr_i = 3'd6; ser_shift(16'h00AA, 8); ser_commit();
    check(slot(6), ID_V, "R9 serial id write");

    det_i = 8'hC5; tick();
    check(slot(1), 8'hC5, "R8 detect follows");
    ser_read(3'd1, 8'hC5, "R8 serial detect");
    ser_read(3'd6, ID_V, "R8 serial id");

    mode_sel = 1'b0; tick();
    rd_n = 1'b0; tick();
    check(sdata_oe, 0, "R10 parallel no serial drive");
    rd_n = 1'b1; tick();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule